// File: doc/BRIEF.md
# Hierarchical Directory Tree Node

This block is one node in a tree of directory caches for a machine where all memory behaves as cache and data has no fixed home. The node keeps set-associative tags with a coherence state (Invalid, Shared, Exclusive) and a presence bit per child for every block held anywhere in its subtree. Every node holds a superset of the entries of the nodes below it. Read misses, write misses, invalidations and replacements arrive from the children and from the parent. The node routes each one up, down, or nowhere, based on two questions: is the block present below this node, and could it also exist outside this subtree?

The node handles one request at a time. A request from the parent takes priority over requests from children. Among children, the lowest index wins. Outgoing messages leave one at a time on a single parent port and a shared child port with a valid bit per child. Each port uses a valid/ready handshake. When an allocation finds its set full, the node first invalidates every holder of the victim entry, so that the subtrees below keep their inclusion. Only then does the original request go on.

Message op codes are 0 read, 1 write, 2 invalidate and 3 evict/place. The set index is address bits [3:0] and the tag is bits [7:4].

Top module: `hdir_node`

## Requirements
- R1: After reset no outgoing message is valid and the parent request port is ready.
- R2: A child read (op 0) of a block that another child holds is forwarded as a read to the lowest-numbered other holder, with nothing sent upward. Otherwise a read goes to the parent. In both cases the requester is added as a holder.
- R3: A child write (op 1) sends an invalidate to every other holder in ascending child order. It then sends a write to the parent, unless the node held the block Exclusive. The requester becomes the only holder and the entry becomes Exclusive.
- R4: A child evict (op 3) that leaves other holders produces no message. An evict by the last holder sends a place message (op 3) to child (c+1) mod N, which becomes the holder. An evict of a block the node does not track is passed to the parent.
- R5: A parent write or invalidate (op 1 or 2) sends an invalidate to every holder in ascending order and removes the entry. For an absent block it produces nothing.
- R6: A parent read of a present block goes as a read to the lowest-numbered holder. For an absent block it produces nothing.
- R7: A parent place message (op 3) is delivered as op 3 to the child given by address bits [1:0], and the entry becomes Exclusive with that child as holder.
- R8: When an allocation finds both ways of its set valid, the victim is the way not most recently written. Each holder of the victim receives an invalidate at the victim address before the request's own messages.
- R9: While a request is in progress, no input port is ready. A parent request is accepted ahead of child requests, and at most one child is ready at a time.
- R10: Op code 2 from a child is ignored: it sends nothing and leaves the directory unchanged.
- R11: At most one outgoing message is valid at a time. A message held by backpressure keeps its valid, op and address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_in_valid_i | input | 1 | Request from parent valid |
| par_in_op_i | input | 2 | Op of parent request |
| par_in_addr_i | input | 8 | Block address of parent request |
| par_in_ready_o | output | 1 | Node accepts parent request |
| chd_in_valid_i | input | 4 | Request valid per child |
| chd_in_op_i | input | 8 | Op per child, 2 bits each |
| chd_in_addr_i | input | 32 | Address per child, 8 bits each |
| chd_in_ready_o | output | 4 | Node accepts request of child |
| par_out_valid_o | output | 1 | Message to parent valid |
| par_out_op_o | output | 2 | Op of message to parent |
| par_out_addr_o | output | 8 | Address of message to parent |
| par_out_ready_i | input | 1 | Parent accepts message |
| chd_out_valid_o | output | 4 | Message valid, one bit per destination child |
| chd_out_op_o | output | 2 | Op of message to child |
| chd_out_addr_o | output | 8 | Address of message to child |
| chd_out_ready_i | input | 4 | Child accepts message |

## Verification
A single block address is taken through a chain of reads, writes and evicts from different children. The chain separates forwarding to a sibling from escalation to the parent, and Shared writes (which go up) from Exclusive writes (which stay local). Evicts by a non-last holder and by the last holder then show a silent drop versus a placement to the next child. Parent reads, invalidates and placements are applied to present and absent blocks to show that the walk stops at the first node without the block. Three addresses that share one set force two successive conflicts, which confirms that the victim is the least recently written way. An op-2 request from a child and a stalled parent port show that nothing leaks out and that inputs stay blocked.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_INV = 2'd2,
    OP_EVT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOOK,
    S_SEND,
    S_UP
  } fsm_e;
endpackage

// File: rtl/hdir_pick.sv
module hdir_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdir_store.sv
module hdir_store
  import hdir_pkg::*;
#(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 2,
  parameter int unsigned TAGW = 4,
  parameter int unsigned NCH  = 4,
  localparam int unsigned IDXW = $clog2(SETS),
  localparam int unsigned WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] idx_i,
  input  logic [TAGW-1:0] tag_i,
  output logic            hit_o,
  output logic [WW-1:0]   hit_way_o,
  output dstate_e         hit_state_o,
  output logic [NCH-1:0]  hit_pres_o,
  output logic            free_o,
  output logic [WW-1:0]   free_way_o,
  output logic [WW-1:0]   vic_way_o,
  output logic [TAGW-1:0] vic_tag_o,
  output logic [NCH-1:0]  vic_pres_o,
  input  logic            wr_i,
  input  logic [WW-1:0]   wr_way_i,
  input  dstate_e         wr_state_i,
  input  logic [TAGW-1:0] wr_tag_i,
  input  logic [NCH-1:0]  wr_pres_i
);
  dstate_e        st_q   [SETS][WAYS];
  logic [TAGW-1:0] tag_q [SETS][WAYS];
  logic [NCH-1:0] pres_q [SETS][WAYS];
  logic [WW-1:0]  ptr_q  [SETS];

  logic [WAYS-1:0] hit_vec, free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w]  = (st_q[idx_i][w] != ST_I) && (tag_q[idx_i][w] == tag_i);
    assign free_vec[w] = (st_q[idx_i][w] == ST_I);
  end

  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way_o  = WW'(w);
      if (free_vec[w]) free_way_o = WW'(w);
    end
  end

  assign hit_o       = |hit_vec;
  assign free_o      = |free_vec;
  assign hit_state_o = st_q[idx_i][hit_way_o];
  assign hit_pres_o  = pres_q[idx_i][hit_way_o];
  assign vic_way_o   = ptr_q[idx_i];
  assign vic_tag_o   = tag_q[idx_i][vic_way_o];
  assign vic_pres_o  = pres_q[idx_i][vic_way_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) st_q[s][w] <= ST_I;
      end
    end else if (wr_i) begin
      st_q[idx_i][wr_way_i] <= wr_state_i;
      // replacement pointer moves past the way just filled
      if (wr_state_i != ST_I)
        ptr_q[idx_i] <= (wr_way_i == WW'(WAYS - 1)) ? '0 : wr_way_i + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      tag_q[idx_i][wr_way_i]  <= wr_tag_i;
      pres_q[idx_i][wr_way_i] <= wr_pres_i;
    end
  end
endmodule

// File: rtl/hdir_node.sv
module hdir_node
  import hdir_pkg::*;
#(
  parameter int unsigned NCH  = 4,
  parameter int unsigned WAYS = 2,
  parameter int unsigned SETS = 16,
  parameter int unsigned AW   = 8,
  localparam int unsigned IDXW = $clog2(SETS),
  localparam int unsigned TAGW = AW - IDXW,
  localparam int unsigned CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_in_valid_i,
  input  logic [1:0]        par_in_op_i,
  input  logic [AW-1:0]     par_in_addr_i,
  output logic              par_in_ready_o,
  input  logic [NCH-1:0]    chd_in_valid_i,
  input  logic [2*NCH-1:0]  chd_in_op_i,
  input  logic [AW*NCH-1:0] chd_in_addr_i,
  output logic [NCH-1:0]    chd_in_ready_o,
  output logic              par_out_valid_o,
  output logic [1:0]        par_out_op_o,
  output logic [AW-1:0]     par_out_addr_o,
  input  logic              par_out_ready_i,
  output logic [NCH-1:0]    chd_out_valid_o,
  output logic [1:0]        chd_out_op_o,
  output logic [AW-1:0]     chd_out_addr_o,
  input  logic [NCH-1:0]    chd_out_ready_i
);
  fsm_e            st_q;
  logic            from_par_q, vic_q, up_q;
  logic [CW-1:0]   src_q;
  op_e             op_q, mop_q, upop_q;
  logic [AW-1:0]   addr_q, maddr_q;
  logic [NCH-1:0]  mask_q;

  logic [IDXW-1:0] idx;
  logic [TAGW-1:0] tg;
  assign idx = addr_q[IDXW-1:0];
  assign tg  = addr_q[AW-1:IDXW];

  logic            hit, free;
  logic [WW-1:0]   hit_way, free_way, vic_way;
  dstate_e         hit_state;
  logic [NCH-1:0]  hit_pres, vic_pres;
  logic [TAGW-1:0] vic_tag;

  logic            l_wr, l_up, l_vic, l_alloc;
  logic [WW-1:0]   l_way;
  dstate_e         l_state;
  logic [NCH-1:0]  l_pres, l_mask;
  op_e             l_mop, l_upop;
  logic [AW-1:0]   l_maddr;

  hdir_store #(.SETS(SETS), .WAYS(WAYS), .TAGW(TAGW), .NCH(NCH)) u_store (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tg),
    .hit_o(hit), .hit_way_o(hit_way), .hit_state_o(hit_state), .hit_pres_o(hit_pres),
    .free_o(free), .free_way_o(free_way),
    .vic_way_o(vic_way), .vic_tag_o(vic_tag), .vic_pres_o(vic_pres),
    .wr_i(l_wr && (st_q == S_LOOK)), .wr_way_i(l_way), .wr_state_i(l_state),
    .wr_tag_i(tg), .wr_pres_i(l_pres)
  );

  // child request arbitration
  logic [NCH-1:0] chd_gnt;
  logic [CW-1:0]  gnt_idx;
  hdir_pick #(.N(NCH)) u_arb (.req_i(chd_in_valid_i), .gnt_o(chd_gnt));

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < NCH; i++) if (chd_gnt[i]) gnt_idx = CW'(i);
  end

  // lowest holder for forwarded reads
  logic [NCH-1:0] src_oh, others, sel_lo, tgt_oh, sib_oh;
  assign src_oh = NCH'(1) << src_q;
  assign others = hit_pres & ~src_oh;
  assign tgt_oh = NCH'(1) << addr_q[CW-1:0];
  assign sib_oh = (src_q == CW'(NCH - 1)) ? NCH'(1) : (NCH'(1) << (src_q + 1'b1));
  hdir_pick #(.N(NCH)) u_lo (.req_i(from_par_q ? hit_pres : others), .gnt_o(sel_lo));

  // next outgoing child message
  logic [NCH-1:0] send_gnt;
  hdir_pick #(.N(NCH)) u_send (.req_i(mask_q), .gnt_o(send_gnt));

  always_comb begin
    l_wr = 1'b0; l_way = hit_way; l_state = hit_state; l_pres = hit_pres;
    l_mask = '0; l_mop = OP_INV; l_maddr = addr_q; l_up = 1'b0; l_upop = op_q;
    l_vic = 1'b0; l_alloc = 1'b0;
    if (from_par_q) begin
      case (op_q)
        OP_RD: if (hit) begin
          l_mask = sel_lo; l_mop = OP_RD; l_wr = 1'b1; l_state = ST_S;
        end
        OP_WR, OP_INV: if (hit) begin
          l_mask = hit_pres; l_wr = 1'b1; l_state = ST_I;
        end
        default: begin
          l_mask = tgt_oh; l_mop = OP_EVT; l_state = ST_E;
          if (hit) begin l_wr = 1'b1; l_pres = hit_pres | tgt_oh; end
          else begin l_alloc = 1'b1; l_pres = tgt_oh; end
        end
      endcase
    end else begin
      case (op_q)
        OP_RD: begin
          if (hit && (others != '0)) begin
            l_mask = sel_lo; l_mop = OP_RD;
          end else begin
            l_up = 1'b1;
          end
          if (hit) begin l_wr = 1'b1; l_pres = hit_pres | src_oh; end
          else begin l_alloc = 1'b1; l_state = ST_S; l_pres = src_oh; end
        end
        OP_WR: begin
          l_mask = hit ? others : '0;
          l_up = !(hit && (hit_state == ST_E));
          l_state = ST_E; l_pres = src_oh;
          if (hit) l_wr = 1'b1;
          else l_alloc = 1'b1;
        end
        OP_INV: ;
        default: begin
          if (!hit) l_up = 1'b1;
          else if (others != '0) begin
            l_wr = 1'b1; l_pres = others;
          end else begin
            // last holder leaves: hand block to next child
            l_mask = sib_oh; l_mop = OP_EVT; l_wr = 1'b1; l_pres = sib_oh;
          end
        end
      endcase
    end
    if (l_alloc) begin
      if (free) begin
        l_wr = 1'b1; l_way = free_way;
      end else begin
        l_wr = 1'b1; l_way = vic_way; l_state = ST_I; l_pres = vic_pres;
        l_mask = vic_pres; l_mop = OP_INV; l_maddr = {vic_tag, idx};
        l_up = 1'b0; l_vic = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; from_par_q <= 1'b0; vic_q <= 1'b0; up_q <= 1'b0;
      src_q <= '0; op_q <= OP_RD; mop_q <= OP_RD; upop_q <= OP_RD;
      addr_q <= '0; maddr_q <= '0; mask_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (par_in_valid_i) begin
            from_par_q <= 1'b1; src_q <= '0;
            op_q <= op_e'(par_in_op_i); addr_q <= par_in_addr_i; st_q <= S_LOOK;
          end else if (|chd_in_valid_i) begin
            from_par_q <= 1'b0; src_q <= gnt_idx;
            op_q <= op_e'(chd_in_op_i[gnt_idx*2 +: 2]);
            addr_q <= chd_in_addr_i[gnt_idx*AW +: AW]; st_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          mask_q <= l_mask; mop_q <= l_mop; maddr_q <= l_maddr;
          vic_q <= l_vic; up_q <= l_up; upop_q <= l_upop; st_q <= S_SEND;
        end
        S_SEND: begin
          if (mask_q == '0) begin
            vic_q <= 1'b0;
            st_q  <= vic_q ? S_LOOK : (up_q ? S_UP : S_IDLE);
          end else if (|(chd_out_valid_o & chd_out_ready_i)) begin
            mask_q <= mask_q & ~send_gnt;
          end
        end
        default: if (par_out_ready_i) st_q <= S_IDLE;
      endcase
    end
  end

  assign par_in_ready_o  = (st_q == S_IDLE);
  assign chd_in_ready_o  = ((st_q == S_IDLE) && !par_in_valid_i) ? chd_gnt : '0;
  assign chd_out_valid_o = (st_q == S_SEND) ? send_gnt : '0;
  assign chd_out_op_o    = mop_q;
  assign chd_out_addr_o  = maddr_q;
  assign par_out_valid_o = (st_q == S_UP);
  assign par_out_op_o    = upop_q;
  assign par_out_addr_o  = addr_q;
endmodule

module hdir_node_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           par_in_valid_i,
  input logic           par_in_ready_o,
  input logic [NCH-1:0] chd_in_valid_i,
  input logic [NCH-1:0] chd_in_ready_o,
  input logic           par_out_valid_o,
  input logic [1:0]     par_out_op_o,
  input logic [AW-1:0]  par_out_addr_o,
  input logic           par_out_ready_i,
  input logic [NCH-1:0] chd_out_valid_o,
  input logic [1:0]     chd_out_op_o,
  input logic [AW-1:0]  chd_out_addr_o,
  input logic [NCH-1:0] chd_out_ready_i
);
  // R11
  one_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chd_out_valid_o, par_out_valid_o}));
  // R11
  up_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_out_valid_o && !par_out_ready_i) |=>
      (par_out_valid_o && $stable(par_out_addr_o) && $stable(par_out_op_o)));
  // R11
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(chd_out_valid_o & ~chd_out_ready_i)) |=>
      ($stable(chd_out_valid_o) && $stable(chd_out_addr_o) && $stable(chd_out_op_o)));
  // R9
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_out_valid_o || (|chd_out_valid_o)) |-> (!par_in_ready_o && (chd_in_ready_o == '0)));
  // R9
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((par_in_valid_i && par_in_ready_o) || (|(chd_in_valid_i & chd_in_ready_o))) |=>
      (!par_in_ready_o && (chd_in_ready_o == '0)));
  // R9
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chd_in_ready_o));
endmodule

bind hdir_node hdir_node_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .par_in_valid_i, .par_in_ready_o, .chd_in_valid_i, .chd_in_ready_o,
  .par_out_valid_o, .par_out_op_o, .par_out_addr_o, .par_out_ready_i,
  .chd_out_valid_o, .chd_out_op_o, .chd_out_addr_o, .chd_out_ready_i
);

// File: tb/tb_hdir_node.sv
`timescale 1ns/1ps
module tb_hdir_node;
  localparam int PAR = 4;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, INV = 2'd2, EVT = 2'd3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        par_v = 1'b0, par_rdy_o, pu_v, pu_rdy = 1'b1;
  logic [1:0]  par_op = '0, pu_op, cd_op;
  logic [7:0]  par_addr = '0, pu_addr, cd_addr;
  logic [3:0]  chd_v = '0, chd_rdy, cd_v, cd_rdy = 4'hf;
  logic [7:0]  chd_op = '0;
  logic [31:0] chd_addr = '0;

  always #4 clk = ~clk;

  hdir_node dut (
    .clk_i(clk), .rst_ni(rst_n),
    .par_in_valid_i(par_v), .par_in_op_i(par_op), .par_in_addr_i(par_addr), .par_in_ready_o(par_rdy_o),
    .chd_in_valid_i(chd_v), .chd_in_op_i(chd_op), .chd_in_addr_i(chd_addr), .chd_in_ready_o(chd_rdy),
    .par_out_valid_o(pu_v), .par_out_op_o(pu_op), .par_out_addr_o(pu_addr), .par_out_ready_i(pu_rdy),
    .chd_out_valid_o(cd_v), .chd_out_op_o(cd_op), .chd_out_addr_o(cd_addr), .chd_out_ready_i(cd_rdy)
  );

  typedef struct {
    int         dst;
    logic [1:0] op;
    logic [7:0] addr;
    string      tag;
  } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_msg(input int dst, input logic [1:0] op, input logic [7:0] a, input string tag);
    item_t it;
    it.dst = dst; it.op = op; it.addr = a; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic compare(input int dst, input logic [1:0] op, input logic [7:0] a);
    item_t it;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R11 unexpected message: actual dst=%0d op=%0d addr=%h expected none", dst, op, a);
    end else begin
      it = exp_q.pop_front();
      if (it.dst != dst || it.op != op || it.addr != a) begin
        n_fail++;
        $display("FAIL %s: actual dst=%0d op=%0d addr=%h expected dst=%0d op=%0d addr=%h",
                 it.tag, dst, op, a, it.dst, it.op, it.addr);
      end
    end
  endtask

  // monitor: sample just after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int c = 0; c < 4; c++) if (cd_v[c] && cd_rdy[c]) compare(c, cd_op, cd_addr);
      if (pu_v && pu_rdy) compare(PAR, pu_op, pu_addr);
    end
  end

  task automatic chd_send(input int c, input logic [1:0] op, input logic [7:0] a);
    @(negedge clk);
    chd_v[c] = 1'b1; chd_op[2*c +: 2] = op; chd_addr[8*c +: 8] = a;
    #1;
    while (!chd_rdy[c]) begin @(negedge clk); #1; end
    @(negedge clk);
    chd_v[c] = 1'b0;
  endtask

  task automatic par_send(input logic [1:0] op, input logic [7:0] a);
    @(negedge clk);
    par_v = 1'b1; par_op = op; par_addr = a;
    #1;
    while (!par_rdy_o) begin @(negedge clk); #1; end
    @(negedge clk);
    par_v = 1'b0;
  endtask

  task automatic settle(input string tag);
    repeat (12) @(negedge clk);
    #2;
    check(exp_q.size() == 0, tag, "messages still owed", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(pu_v == 1'b0 && cd_v == 4'h0, "R1", "outgoing valid in reset", {pu_v, cd_v}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(par_rdy_o == 1'b1, "R1", "parent ready after reset", par_rdy_o, 1);
    check(pu_v == 1'b0 && cd_v == 4'h0, "R1", "outgoing valid after reset", {pu_v, cd_v}, 0);

    // R2 miss goes up, then hit forwards to sibling
    expect_msg(PAR, RD, 8'h15, "R2"); chd_send(0, RD, 8'h15); settle("R2");
    expect_msg(0, RD, 8'h15, "R2");   chd_send(1, RD, 8'h15); settle("R2");
    // R3 write on shared: invalidate holders then go up
    expect_msg(0, INV, 8'h15, "R3"); expect_msg(1, INV, 8'h15, "R3");
    expect_msg(PAR, WR, 8'h15, "R3"); chd_send(2, WR, 8'h15); settle("R3");
    // R2 read inside an exclusive subtree
    expect_msg(2, RD, 8'h15, "R2"); chd_send(3, RD, 8'h15); settle("R2");
    // R3 write on exclusive stays local
    expect_msg(2, INV, 8'h15, "R3"); chd_send(3, WR, 8'h15); settle("R3");
    // R4 last holder leaves: placed at next child (3 -> 0)
    expect_msg(0, EVT, 8'h15, "R4"); chd_send(3, EVT, 8'h15); settle("R4");
    // R4 non-last holder leaves silently
    expect_msg(0, RD, 8'h15, "R2"); chd_send(1, RD, 8'h15); settle("R2");
    chd_send(0, EVT, 8'h15); settle("R4");
    expect_msg(1, RD, 8'h15, "R4"); chd_send(2, RD, 8'h15); settle("R4");
    // R5 parent invalidate of present block, then entry is gone
    expect_msg(1, INV, 8'h15, "R5"); expect_msg(2, INV, 8'h15, "R5");
    par_send(INV, 8'h15); settle("R5");
    expect_msg(PAR, RD, 8'h15, "R5"); chd_send(3, RD, 8'h15); settle("R5");
    // R6 parent read of absent block stops here
    par_send(RD, 8'h25); settle("R6");
    // R5 parent invalidate of absent block
    par_send(INV, 8'h47); settle("R5");
    // R7 placement by address low bits
    expect_msg(2, EVT, 8'h26, "R7"); par_send(EVT, 8'h26); settle("R7");
    // R8 set conflicts in set 5
    expect_msg(PAR, RD, 8'h25, "R8"); chd_send(0, RD, 8'h25); settle("R8");
    expect_msg(3, INV, 8'h15, "R8"); expect_msg(PAR, RD, 8'h35, "R8");
    chd_send(1, RD, 8'h35); settle("R8");
    expect_msg(0, INV, 8'h25, "R8"); expect_msg(PAR, RD, 8'h15, "R8");
    chd_send(2, RD, 8'h15); settle("R8");
    // R10 op 2 from child ignored; entry for 0x26 unchanged
    chd_send(1, INV, 8'h26); settle("R10");
    expect_msg(2, RD, 8'h26, "R10"); par_send(RD, 8'h26); settle("R10");
    // R4 evict of untracked block goes up
    expect_msg(PAR, EVT, 8'h77, "R4"); chd_send(0, EVT, 8'h77); settle("R4");

    // R9 / R11 backpressure on the parent port holds everything
    pu_rdy = 1'b0;
    expect_msg(PAR, RD, 8'h99, "R11");
    chd_send(1, RD, 8'h99);
    @(negedge clk);
    chd_v[2] = 1'b1; chd_op[5:4] = RD; chd_addr[23:16] = 8'h99;
    expect_msg(1, RD, 8'h99, "R9");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check(chd_rdy[2] == 1'b0, "R9", "child ready while busy", chd_rdy[2], 0);
      check(pu_v == 1'b1 && pu_addr == 8'h99, "R11", "held upward message", pu_addr, 8'h99);
    end
    pu_rdy = 1'b1;
    #1;
    while (!chd_rdy[2]) begin @(negedge clk); #1; end
    @(negedge clk);
    chd_v[2] = 1'b0;
    settle("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule